// File: doc/BRIEF.md
# Byte Program Sequencer for Parallel Flash

This block is a host-side controller that writes single bytes into a 5 V parallel NOR-style flash. For each byte it applies one write strobe, then waits out the flash's internally timed program pulse and the write recovery time. It then reads the location back and compares it with the requested value. If the byte does not match, it strobes the same byte again. This continues until the byte verifies or the retry limit is used up. All strobe widths and waits are whole clock cycles, derived from the system clock frequency and rounded up.

A request arrives on a valid/ready handshake and carries an address, a data byte and a fill flag. With the fill flag set, the block does not use the data byte. Instead it walks every address from the start address up to and including the end address, and programs 00h into each one. This is the zero-fill that a flash needs before it is erased. Each byte in the walk gets its own retry loop. The walk stops at the first byte that cannot be programmed.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, busy_o=0, req_ready_o=1, done_o=0, fail_o=0 and attempts_o=0. All three strobes are high and the data bus is released.
- R2: A request is taken only when req_valid_i and req_ready_o are both high, and req_ready_o is high only while the block is idle. A request held valid while the block is busy is not taken and leaves the flash untouched.
- R3: Each write strobe holds fl_we_no low for at least 40 ns. Between two write strobes, fl_we_no stays high for at least 20 ns.
- R4: While fl_we_no is low, the address and data are stable and the data bus is driven. For at least 10 ns after fl_we_no rises, fl_ce_no stays low and the data bus stays driven.
- R5: fl_oe_no falls no earlier than the 10 µs program pulse plus the 6 µs recovery, measured from the rising edge of fl_we_no.
- R6: A verify read holds fl_ce_no and fl_oe_no low for ceil(ACC_NS) cycles and captures the bus on its last cycle. The block never drives the data bus while fl_oe_no is low, and fl_oe_no and fl_we_no are never low together.
- R7: When the last byte verifies, busy_o falls. In that same cycle done_o is high for exactly one cycle, and attempts_o shows the number of strobes the last byte took, counting from 1.
- R8: A byte that fails to verify is strobed again, up to MAX_TRIES=25 strobes. If the 25th verify also fails, fail_o pulses for one cycle with attempts_o=25, and done_o stays low.
- R9: In fill mode, 00h is programmed into every address from req_addr_i to req_end_i inclusive, in ascending order. The first failing byte ends the walk with fail_o, and the higher addresses are left unwritten.
- R10: busy_o rises in the cycle after a request is accepted. It stays high for exactly N × (WP + DH + PP + WR + ACC + 1) cycles, where N is the total number of strobes and each term is its time rounded up to whole cycles. At 125 MHz this is 2021 cycles per strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Idle, request can be taken |
| req_fill_i | input | 1 | 1: zero-fill the address range; 0: program one byte |
| req_addr_i | input | AW | Byte address, or start of the fill range |
| req_end_i | input | AW | Last address of the fill range |
| req_data_i | input | DW | Byte to program (ignored in fill mode) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse: every byte verified |
| fail_o | output | 1 | One-cycle pulse: retry limit reached |
| attempts_o | output | ATT_W | Strobes used on the current or last byte |
| fl_addr_o | output | AW | Flash address bus |
| fl_dq_io | inout | DW | Flash data bus |
| fl_ce_no | output | 1 | Flash chip enable, active low |
| fl_we_no | output | 1 | Flash write enable, active low |
| fl_oe_no | output | 1 | Flash output enable, active low |

## Verification
A timer or phase that is wrong inside the block shows up at the ports on the next edge of busy_o. The busy window of every request has a closed-form length, so a single lost or extra cycle moves the fall of busy_o and the done_o or fail_o pulse. The bench compares these against its model on every clock. A retry counter that is wrong shows up in attempts_o and in the pulse that ends the request. A broken address walk leaves the wrong bytes at 00h, or leaves 00h bytes outside the range. Both show up in the flash model's contents right after done_o or fail_o.

// File: rtl/fps_pkg.sv
package fps_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_WLOW, S_WHOLD, S_PULSE, S_RECOV, S_READ, S_CHECK
  } fps_state_e;

  // ceil(ns * hz / 1e9), never below one cycle
  function automatic int unsigned ns_to_cyc(input longint unsigned ns, input longint unsigned hz);
    longint unsigned c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    return (c == 64'd0) ? 32'd1 : c[31:0];
  endfunction
endpackage

// File: rtl/fps_timer.sv
module fps_timer #(
  parameter int unsigned TW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fps_addr_walker.sv
module fps_addr_walker #(
  parameter int unsigned AW = 17
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] first_i,
  input  logic [AW-1:0] last_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          at_last_o
);
  logic [AW-1:0] cur_q, last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      last_q <= '0;
    end else if (start_i) begin
      cur_q  <= first_i;
      last_q <= last_i;
    end else if (step_i) begin
      cur_q  <= cur_q + 1'b1;
    end
  end

  assign addr_o    = cur_q;
  assign at_last_o = (cur_q == last_q);
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import fps_pkg::*;
#(
  parameter longint unsigned CLK_HZ    = 125_000_000,
  parameter int unsigned     AW        = 17,
  parameter int unsigned     DW        = 8,
  parameter int unsigned     ATT_W     = 5,
  parameter int unsigned     MAX_TRIES = 25,
  parameter int unsigned     WP_NS     = 40,
  parameter int unsigned     WPH_NS    = 20,
  parameter int unsigned     DH_NS     = 10,
  parameter int unsigned     PP_NS     = 10_000,
  parameter int unsigned     WR_NS     = 6_000,
  parameter int unsigned     ACC_NS    = 100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_fill_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [AW-1:0] req_end_i,
  input  logic [DW-1:0] req_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic [ATT_W-1:0] attempts_o,
  output logic [AW-1:0] fl_addr_o,
  inout  wire  [DW-1:0] fl_dq_io,
  output logic          fl_ce_no,
  output logic          fl_we_no,
  output logic          fl_oe_no
);
  localparam int unsigned WP_CYC  = ns_to_cyc(WP_NS, CLK_HZ);
  localparam int unsigned DH_CYC  = ns_to_cyc(DH_NS, CLK_HZ);
  localparam int unsigned PP_CYC  = ns_to_cyc(PP_NS, CLK_HZ);
  localparam int unsigned WR_CYC  = ns_to_cyc(WR_NS, CLK_HZ);
  localparam int unsigned ACC_CYC = ns_to_cyc(ACC_NS, CLK_HZ);
  localparam int unsigned M1      = (PP_CYC > WR_CYC) ? PP_CYC : WR_CYC;
  localparam int unsigned M2      = (WP_CYC > ACC_CYC) ? WP_CYC : ACC_CYC;
  localparam int unsigned M3      = (M1 > M2) ? M1 : M2;
  localparam int unsigned MAX_CYC = (M3 > DH_CYC) ? M3 : DH_CYC;
  localparam int unsigned TW      = $clog2(MAX_CYC + 1);

  fps_state_e state_q, state_d;
  logic [DW-1:0]    data_q, rd_q;
  logic [ATT_W-1:0] att_q;
  logic             done_q, fail_q;
  logic             we_n_q, ce_n_q, oe_n_q, drv_q;
  logic             tmr_ld, tmr_zero;
  logic [TW-1:0]    tmr_val;
  logic             walk_start, walk_step, at_last;
  logic             match, last_try, accept;

  assign accept   = req_valid_i && (state_q == S_IDLE);
  assign match    = (rd_q == data_q);
  assign last_try = (att_q == ATT_W'(MAX_TRIES));

  fps_timer #(.TW(TW)) i_timer (
    .clk_i, .rst_ni,
    .load_i (tmr_ld),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  fps_addr_walker #(.AW(AW)) i_walker (
    .clk_i, .rst_ni,
    .start_i   (walk_start),
    .first_i   (req_addr_i),
    .last_i    (req_fill_i ? req_end_i : req_addr_i),
    .step_i    (walk_step),
    .addr_o    (fl_addr_o),
    .at_last_o (at_last)
  );

  always_comb begin
    state_d    = state_q;
    tmr_ld     = 1'b0;
    tmr_val    = '0;
    walk_start = 1'b0;
    walk_step  = 1'b0;
    unique case (state_q)
      S_IDLE: if (accept) begin
        state_d = S_WLOW; tmr_ld = 1'b1; tmr_val = TW'(WP_CYC - 1); walk_start = 1'b1;
      end
      S_WLOW: if (tmr_zero) begin
        state_d = S_WHOLD; tmr_ld = 1'b1; tmr_val = TW'(DH_CYC - 1);
      end
      S_WHOLD: if (tmr_zero) begin
        state_d = S_PULSE; tmr_ld = 1'b1; tmr_val = TW'(PP_CYC - 1);
      end
      S_PULSE: if (tmr_zero) begin
        state_d = S_RECOV; tmr_ld = 1'b1; tmr_val = TW'(WR_CYC - 1);
      end
      S_RECOV: if (tmr_zero) begin
        state_d = S_READ; tmr_ld = 1'b1; tmr_val = TW'(ACC_CYC - 1);
      end
      S_READ: if (tmr_zero) state_d = S_CHECK;
      S_CHECK: begin
        if (match ? at_last : last_try) begin
          state_d = S_IDLE;
        end else begin
          state_d   = S_WLOW; tmr_ld = 1'b1; tmr_val = TW'(WP_CYC - 1);
          walk_step = match;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      data_q  <= '0;
      rd_q    <= '0;
      att_q   <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      we_n_q  <= 1'b1;
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      drv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == S_CHECK) && match && at_last;
      fail_q  <= (state_q == S_CHECK) && !match && last_try;
      // strobes decoded from next state so they line up with the phase
      we_n_q  <= !(state_d == S_WLOW);
      ce_n_q  <= !(state_d inside {S_WLOW, S_WHOLD, S_READ});
      oe_n_q  <= !(state_d == S_READ);
      drv_q   <= (state_d inside {S_WLOW, S_WHOLD});
      if (accept) begin
        data_q <= req_fill_i ? '0 : req_data_i;
        att_q  <= ATT_W'(1);
      end else if (state_q == S_CHECK && !(match ? at_last : last_try)) begin
        att_q  <= match ? ATT_W'(1) : att_q + 1'b1;
      end
      if (state_q == S_READ && tmr_zero) rd_q <= fl_dq_io;
    end
  end

  assign fl_dq_io    = drv_q ? data_q : 'z;
  assign fl_we_no    = we_n_q;
  assign fl_ce_no    = ce_n_q;
  assign fl_oe_no    = oe_n_q;
  assign busy_o      = (state_q != S_IDLE);
  assign req_ready_o = (state_q == S_IDLE);
  assign done_o      = done_q;
  assign fail_o      = fail_q;
  assign attempts_o  = att_q;
endmodule

// File: rtl/fps_checker.sv
module fps_checker
  import fps_pkg::*;
#(
  parameter longint unsigned CLK_HZ    = 125_000_000,
  parameter int unsigned     AW        = 17,
  parameter int unsigned     DW        = 8,
  parameter int unsigned     ATT_W     = 5,
  parameter int unsigned     MAX_TRIES = 25,
  parameter int unsigned     WP_NS     = 40,
  parameter int unsigned     WPH_NS    = 20,
  parameter int unsigned     DH_NS     = 10,
  parameter int unsigned     PP_NS     = 10_000,
  parameter int unsigned     WR_NS     = 6_000
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fl_we_no,
  input logic             fl_ce_no,
  input logic             fl_oe_no,
  input logic [AW-1:0]    fl_addr_o,
  input logic [DW-1:0]    dq_val,
  input logic             dq_drv,
  input logic             busy_o,
  input logic             done_o,
  input logic             fail_o,
  input logic [ATT_W-1:0] attempts_o
);
  localparam int unsigned WP_CYC  = ns_to_cyc(WP_NS, CLK_HZ);
  localparam int unsigned WPH_CYC = ns_to_cyc(WPH_NS, CLK_HZ);
  localparam int unsigned DH_CYC  = ns_to_cyc(DH_NS, CLK_HZ);
  localparam int unsigned REC_CYC = ns_to_cyc(PP_NS, CLK_HZ) + ns_to_cyc(WR_NS, CLK_HZ);

  logic [31:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt <= '0;
      hi_cnt <= '1;
    end else begin
      lo_cnt <= fl_we_no ? '0 : lo_cnt + 1;
      hi_cnt <= !fl_we_no ? '0 : ((hi_cnt != '1) ? hi_cnt + 1 : hi_cnt);
    end
  end

  a_r3_we_low_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fl_we_no) |-> lo_cnt >= WP_CYC);
  a_r3_we_high_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fl_we_no) |-> hi_cnt >= WPH_CYC);
  a_r4_bus_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fl_we_no && $past(!fl_we_no)) |-> ($stable(fl_addr_o) && $stable(dq_val) && dq_drv));
  a_r4_hold_after_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fl_we_no) |-> (dq_drv && !fl_ce_no && DH_CYC >= 1));
  a_r5_recovery: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fl_oe_no) |-> hi_cnt >= REC_CYC);
  a_r6_no_drive_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_oe_no |-> (!dq_drv && !fl_ce_no && fl_we_no));
  a_r8_attempt_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attempts_o <= ATT_W'(MAX_TRIES));
  a_r7_done_fail_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));
  a_r7_end_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fail_o) |-> (!busy_o && $past(busy_o)));
endmodule

bind flash_prog_seq fps_checker #(
  .CLK_HZ(CLK_HZ), .AW(AW), .DW(DW), .ATT_W(ATT_W), .MAX_TRIES(MAX_TRIES),
  .WP_NS(WP_NS), .WPH_NS(WPH_NS), .DH_NS(DH_NS), .PP_NS(PP_NS), .WR_NS(WR_NS)
) i_fps_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .fl_we_no(fl_we_no), .fl_ce_no(fl_ce_no),
  .fl_oe_no(fl_oe_no), .fl_addr_o(fl_addr_o), .dq_val(data_q), .dq_drv(drv_q),
  .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o), .attempts_o(attempts_o)
);

// File: tb/test_flash_prog_seq.sv
`timescale 1ns/1ps
module test_flash_prog_seq;
  localparam int AW = 17;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_fill = 1'b0;
  logic [AW-1:0] req_addr = '0, req_end = '0;
  logic [DW-1:0] req_data = '0;
  logic req_ready, busy, done, fail;
  logic [4:0] attempts;
  logic [AW-1:0] fl_addr;
  wire  [DW-1:0] fl_dq;
  logic fl_ce_n, fl_we_n, fl_oe_n;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  flash_prog_seq i_flash_prog_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_fill_i(req_fill), .req_addr_i(req_addr), .req_end_i(req_end), .req_data_i(req_data),
    .busy_o(busy), .done_o(done), .fail_o(fail), .attempts_o(attempts),
    .fl_addr_o(fl_addr), .fl_dq_io(fl_dq), .fl_ce_no(fl_ce_n), .fl_we_no(fl_we_n),
    .fl_oe_no(fl_oe_n)
  );

  // Flash model: a location takes the byte only after need[a] write strobes
  logic [7:0] mem [256];
  int need [256];
  int pulses [256];

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'hFF; need[i] = 1; pulses[i] = 0;
    end
    need[8'h11] = 3; need[8'h12] = 30;
    need[8'h21] = 2; need[8'h23] = 4;
    need[8'h31] = 26;
  end

  always @(posedge fl_we_n) begin
    if (fl_ce_n === 1'b0) begin
      pulses[fl_addr[7:0]] = pulses[fl_addr[7:0]] + 1;
      if (pulses[fl_addr[7:0]] >= need[fl_addr[7:0]]) mem[fl_addr[7:0]] = fl_dq;
    end
  end

  assign fl_dq = (fl_ce_n === 1'b0 && fl_oe_n === 1'b0) ? mem[fl_addr[7:0]] : 8'bz;

  // Expected timing from the requirements at 125 MHz
  function automatic longint cyc(input longint ns);
    longint c;
    c = (ns * 125_000_000 + 999_999_999) / 1_000_000_000;
    return (c < 1) ? 1 : c;
  endfunction
  localparam longint PER_TRY = cyc(40) + cyc(10) + cyc(10_000) + cyc(6_000) + cyc(100) + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // Drives one request and compares the handshake and status every clock
  task automatic run_req(input bit fill, input int a0, input int a1, input int d,
                         input int total_tries, input int last_tries, input bit exp_fail,
                         input bit hold_valid);
    @(negedge clk);
    req_fill = fill; req_addr = AW'(a0); req_end = AW'(a1); req_data = DW'(d);
    req_valid = 1'b1;
    chk(req_ready === 1'b1, "R2 ready before accept", longint'(req_ready), 1);
    @(negedge clk);
    if (hold_valid) begin
      req_fill = 1'b0; req_addr = AW'(8'h40); req_data = 8'h11;
    end else begin
      req_valid = 1'b0;
    end
    for (longint i = 0; i < total_tries * PER_TRY; i++) begin
      chk(busy === 1'b1, "R10 busy window", longint'(busy), 1);
      chk(done === 1'b0 && fail === 1'b0, "R10 no early end", longint'({done, fail}), 0);
      chk(req_ready === 1'b0, "R2 ready low while busy", longint'(req_ready), 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(busy === 1'b0, "R10 busy falls", longint'(busy), 0);
    chk(done === !exp_fail, "R7 done pulse", longint'(done), longint'(!exp_fail));
    chk(fail === exp_fail, "R8 fail pulse", longint'(fail), longint'(exp_fail));
    chk(attempts === 5'(last_tries), "R7 R8 attempts", longint'(attempts), longint'(last_tries));
    @(negedge clk);
    chk(done === 1'b0 && fail === 1'b0, "R7 pulse one cycle", longint'({done, fail}), 0);
    chk(busy === 1'b0, "R2 no hidden accept", longint'(busy), 0);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190_000) begin
        compared++; mismatched++;
        $display("FAIL watchdog actual=%0d expected<190000", cycles);
        summary();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy === 1'b0 && req_ready === 1'b1, "R1 idle", longint'({busy, req_ready}), 1);
    chk({fl_ce_n, fl_we_n, fl_oe_n} === 3'b111, "R1 strobes", longint'({fl_ce_n, fl_we_n, fl_oe_n}), 7);
    chk(attempts === 5'd0 && done === 1'b0 && fail === 1'b0, "R1 status", longint'(attempts), 0);
    chk(fl_dq === 8'bz, "R1 bus released", longint'(fl_dq), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 R4 R5 R6 R7: single byte, first strobe verifies
    run_req(1'b0, 8'h10, 8'h10, 8'h5A, 1, 1, 1'b0, 1'b0);
    chk(mem[8'h10] === 8'h5A, "R7 byte stored", longint'(mem[8'h10]), 8'h5A);

    // R8 R2: three strobes needed, a request held valid while busy is ignored
    run_req(1'b0, 8'h11, 8'h11, 8'hC3, 3, 3, 1'b0, 1'b1);
    chk(mem[8'h11] === 8'hC3, "R8 retried byte", longint'(mem[8'h11]), 8'hC3);
    chk(mem[8'h40] === 8'hFF && pulses[8'h40] == 0, "R2 busy request ignored",
        longint'(mem[8'h40]), 8'hFF);
    chk(pulses[8'h11] == 3, "R8 strobe count", longint'(pulses[8'h11]), 3);

    // R8: never verifies, stops at 25
    run_req(1'b0, 8'h12, 8'h12, 8'h77, 25, 25, 1'b1, 1'b0);
    chk(pulses[8'h12] == 25, "R8 limit strobes", longint'(pulses[8'h12]), 25);
    chk(mem[8'h12] === 8'hFF, "R8 byte unprogrammed", longint'(mem[8'h12]), 8'hFF);

    // R9: zero-fill 0x20..0x23, needs 1,2,1,4; data input ignored
    run_req(1'b1, 8'h20, 8'h23, 8'hA5, 8, 4, 1'b0, 1'b0);
    for (int a = 8'h20; a <= 8'h23; a++)
      chk(mem[a] === 8'h00, "R9 range zeroed", longint'(mem[a]), 0);
    chk(mem[8'h24] === 8'hFF && mem[8'h1F] === 8'hFF, "R9 outside range",
        longint'(mem[8'h24]), 8'hFF);

    // R9: fill stops at first failing byte
    run_req(1'b1, 8'h30, 8'h32, 8'h00, 26, 25, 1'b1, 1'b0);
    chk(mem[8'h30] === 8'h00, "R9 first byte", longint'(mem[8'h30]), 0);
    chk(mem[8'h32] === 8'hFF && pulses[8'h32] == 0, "R9 walk halted",
        longint'(pulses[8'h32]), 0);

    summary();
  end
endmodule